// File: doc/BRIEF.md
# Two-Operand Bit-Merge and Byte-Align Unit

This unit builds one 32-bit word out of two source words. It is meant for assembling bit streams in a datapath. Four merge operations are available, and each one reads the shared amount input in its own way:

- **Append** slides the second operand up and feeds low bits of the first operand in underneath it.
- **Prepend** slides the second operand down and feeds low bits of the first operand in above it.
- **Byte-align** joins the two operands on a byte boundary.
- **Pack-right-left** exchanges halfwords between the two operands.

The operation is captured on the clock edge where `op_valid` is high. The result appears on the registered outputs one cycle later and stays there until the next valid operation. A sign-extended 64-bit copy of the result is also provided, for use with a wider register file. An opcode that is not defined returns zero and raises a flag for a single cycle.

Opcode encoding on `op_code`: 0 = append, 1 = prepend, 2 = byte-align, 3 = pack-right-left, and 4 to 7 are undefined. In what follows, `a` is `src_a` and `b` is `src_b`.

Top module: `merge_align_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first valid operation, `result`, `result_ext` and `illegal_op` are all zero.
- R2: Append (op 0) with amount s gives `(b << s) | (a & ((1<<s)-1))`, truncated to 32 bits.
- R3: Append with s = 0 gives `b` unchanged, and no bit of `a` enters the result.
- R4: Prepend (op 1) with amount s > 0 gives `(a << (32-s)) | (b >> s)`, truncated to 32 bits.
- R5: Prepend with s = 0 gives `b` unchanged.
- R6: Append and prepend use only `amount[4:0]`. Byte-align uses only `amount[1:0]`. All higher amount bits are ignored.
- R7: Byte-align (op 2) with an even position p = `amount[1:0]` (0 or 2) gives `b` unchanged.
- R8: Byte-align with an odd position p (1 or 3) gives `(b << 8p) | (a >> 8(4-p))`.
- R9: Pack-right-left (op 3) gives `{a[15:0], b[31:16]}`.
- R10: An undefined opcode (4 to 7) sets `result` to zero. It also drives `illegal_op` high for exactly the one cycle after that operation is accepted.
- R11: `result_ext` always equals `result` sign-extended from bit 31 to 64 bits.
- R12: `result` changes one cycle after a clock edge on which `op_valid` is high. It holds its value while `op_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Accepts an operation on this edge |
| op_code | input | 3 | Operation select (see encoding) |
| src_a | input | 32 | First operand, the fill source |
| src_b | input | 32 | Second operand, the shifted word |
| amount | input | 8 | Shift amount or byte position; only the low bits are used |
| result | output | 32 | Registered merge result |
| result_ext | output | 64 | Result sign-extended from bit 31 |
| illegal_op | output | 1 | One-cycle pulse after an undefined opcode |

## Verification
The bench drives a zero amount into both append and prepend. A design that builds its mask or its complementary shift naively fails here: it either pulls bits of `a` into an append, or it shifts `a` by a full 32 bits in a prepend. The bench also drives amounts that carry set bits above the used field; a design with an unmasked amount would shift by the wrong distance. Byte-align is run at all four positions plus a position with high bits set, which exposes any mix-up between the odd case and the even pass-through. Negative results exercise the 64-bit extension. Idle cycles after an illegal opcode catch a flag that stays high or a result that drifts while no operation is accepted.

// File: rtl/merge_align_pkg.sv
package merge_align_pkg;
  typedef enum logic [2:0] {
    OP_APPEND  = 3'd0,
    OP_PREPEND = 3'd1,
    OP_BALIGN  = 3'd2,
    OP_PACKRL  = 3'd3
  } merge_op_e;
endpackage

// File: rtl/shift_merge.sv
module shift_merge #(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SH_W-1:0]   sh_i,
  output logic [DATA_W-1:0] append_o,
  output logic [DATA_W-1:0] prepend_o
);
  // b moves up, low s bits of a fill beneath
  function automatic logic [DATA_W-1:0] f_append(
    input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b, input logic [SH_W-1:0] s);
    logic [DATA_W-1:0] keep;
    keep = ~({DATA_W{1'b1}} << s);
    return (b << s) | (a & keep);
  endfunction

  // b moves down, low s bits of a fill above; s = 0 passes b
  function automatic logic [DATA_W-1:0] f_prepend(
    input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b, input logic [SH_W-1:0] s);
    int unsigned up;
    if (s == '0) return b;
    up = DATA_W - int'(s);
    return (a << up) | (b >> s);
  endfunction

  always_comb begin
    append_o  = f_append(a_i, b_i, sh_i);
    prepend_o = f_prepend(a_i, b_i, sh_i);
  end
endmodule

// File: rtl/byte_merge.sv
module byte_merge #(
  parameter int DATA_W = 32,
  localparam int NB   = DATA_W / 8,
  localparam int BP_W = $clog2(NB),
  localparam int HW   = DATA_W / 2
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [BP_W-1:0]   pos_i,
  output logic [DATA_W-1:0] align_o,
  output logic [DATA_W-1:0] pack_o
);
  // even position passes b; odd joins b's low bytes with a's high bytes
  function automatic logic [DATA_W-1:0] f_align(
    input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b, input logic [BP_W-1:0] p);
    int unsigned up, dn;
    if (!p[0]) return b;
    up = 8 * int'(p);
    dn = 8 * (NB - int'(p));
    return (b << up) | (a >> dn);
  endfunction

  function automatic logic [DATA_W-1:0] f_pack(
    input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return {a[HW-1:0], b[DATA_W-1:HW]};
  endfunction

  always_comb begin
    align_o = f_align(a_i, b_i, pos_i);
    pack_o  = f_pack(a_i, b_i);
  end
endmodule

// File: rtl/merge_align_unit.sv
module merge_align_unit #(
  parameter int DATA_W   = 32,
  parameter int AMT_IN_W = 8,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int BP_W  = $clog2(DATA_W / 8),
  localparam int EXT_W = 2 * DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [2:0]          op_code,
  input  logic [DATA_W-1:0]   src_a,
  input  logic [DATA_W-1:0]   src_b,
  input  logic [AMT_IN_W-1:0] amount,
  output logic [DATA_W-1:0]   result,
  output logic [EXT_W-1:0]    result_ext,
  output logic                illegal_op
);
  import merge_align_pkg::*;

  logic [SH_W-1:0]   amt_eff;
  logic [BP_W-1:0]   pos_eff;
  logic              unused_amt_hi;
  logic [DATA_W-1:0] app_w, pre_w, aln_w, pck_w, sel_w;
  logic              bad_op_w;
  logic              app_zero_w, pre_zero_w, aln_even_w;

  assign amt_eff       = amount[SH_W-1:0];
  assign pos_eff       = amount[BP_W-1:0];
  assign unused_amt_hi = ^amount[AMT_IN_W-1:SH_W];

  shift_merge #(.DATA_W(DATA_W)) u_shift (
    .a_i(src_a), .b_i(src_b), .sh_i(amt_eff),
    .append_o(app_w), .prepend_o(pre_w)
  );

  byte_merge #(.DATA_W(DATA_W)) u_byte (
    .a_i(src_a), .b_i(src_b), .pos_i(pos_eff),
    .align_o(aln_w), .pack_o(pck_w)
  );

  always_comb begin
    bad_op_w = 1'b0;
    case (op_code)
      OP_APPEND:  sel_w = app_w;
      OP_PREPEND: sel_w = pre_w;
      OP_BALIGN:  sel_w = aln_w;
      OP_PACKRL:  sel_w = pck_w;
      default: begin
        sel_w    = '0;
        bad_op_w = 1'b1;
      end
    endcase
  end

  // events named for the checks below
  assign app_zero_w = op_valid && (op_code == OP_APPEND)  && (amt_eff == '0);
  assign pre_zero_w = op_valid && (op_code == OP_PREPEND) && (amt_eff == '0);
  assign aln_even_w = op_valid && (op_code == OP_BALIGN)  && !pos_eff[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result     <= '0;
      illegal_op <= 1'b0;
    end else begin
      illegal_op <= op_valid && bad_op_w;
      if (op_valid) result <= sel_w;
    end
  end

  assign result_ext = {{(EXT_W-DATA_W){result[DATA_W-1]}}, result};

  assert_append_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    app_zero_w |=> (result == $past(src_b)));

  assert_prepend_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_zero_w |=> (result == $past(src_b)));

  assert_align_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
    aln_even_w |=> (result == $past(src_b)));

  assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && bad_op_w) |=> (illegal_op && (result == '0)));

  assert_illegal_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !illegal_op);

  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(result));
endmodule

// File: tb/test_merge_align_unit.sv
module test_merge_align_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [7:0]  amount = '0;
  logic [31:0] result;
  logic [63:0] result_ext;
  logic        illegal_op;

  int checks = 0;
  int errors = 0;

  merge_align_unit i_merge_align_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .amount(amount),
    .result(result), .result_ext(result_ext), .illegal_op(illegal_op)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [7:0]  amt;
    logic [31:0] exp;
    logic        ill;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h89ABCDEF, 32'h12345678, 8'd8,   32'h345678EF, 1'b0}, // R2
    '{3'd0, 32'h89ABCDEF, 32'h12345678, 8'd0,   32'h12345678, 1'b0}, // R3
    '{3'd0, 32'h89ABCDEF, 32'h12345678, 8'd31,  32'h09ABCDEF, 1'b0}, // R2 top
    '{3'd0, 32'h89ABCDEF, 32'h12345678, 8'h24,  32'h2345678F, 1'b0}, // R6
    '{3'd1, 32'h89ABCDEF, 32'h12345678, 8'd8,   32'hEF123456, 1'b0}, // R4
    '{3'd1, 32'h89ABCDEF, 32'h12345678, 8'd0,   32'h12345678, 1'b0}, // R5
    '{3'd1, 32'h89ABCDEF, 32'h12345678, 8'd16,  32'hCDEF1234, 1'b0}, // R4
    '{3'd1, 32'h89ABCDEF, 32'h12345678, 8'hE4,  32'hF1234567, 1'b0}, // R6
    '{3'd2, 32'h89ABCDEF, 32'h12345678, 8'd0,   32'h12345678, 1'b0}, // R7
    '{3'd2, 32'h89ABCDEF, 32'h12345678, 8'd2,   32'h12345678, 1'b0}, // R7
    '{3'd2, 32'h89ABCDEF, 32'h12345678, 8'd1,   32'h34567889, 1'b0}, // R8
    '{3'd2, 32'h89ABCDEF, 32'h12345678, 8'd3,   32'h7889ABCD, 1'b0}, // R8
    '{3'd2, 32'h89ABCDEF, 32'h12345678, 8'd5,   32'h34567889, 1'b0}, // R6
    '{3'd3, 32'h89ABCDEF, 32'h12345678, 8'd0,   32'hCDEF1234, 1'b0}, // R9
    '{3'd3, 32'h0000FFFF, 32'hFFFF0000, 8'd7,   32'hFFFFFFFF, 1'b0}, // R9
    '{3'd5, 32'h89ABCDEF, 32'h12345678, 8'd3,   32'h00000000, 1'b1}, // R10
    '{3'd7, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'd1,   32'h00000000, 1'b1}  // R10
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [7:0] amt);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; src_a = a; src_b = b; amount = amt;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 result in reset", {32'h0, result}, 64'h0);
    check("R1 flag in reset", {63'h0, illegal_op}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ext after reset", result_ext, 64'h0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].amt);
      check($sformatf("R2-table vector %0d result", i), {32'h0, result}, {32'h0, VECS[i].exp});
      check($sformatf("R10 vector %0d flag", i), {63'h0, illegal_op}, {63'h0, VECS[i].ill});
      check($sformatf("R11 vector %0d ext", i), result_ext, {{32{VECS[i].exp[31]}}, VECS[i].exp});
    end

    // R10 flag lasts one cycle; R12 result held while idle with changing inputs
    issue(3'd4, 32'h1, 32'h2, 8'd0);
    check("R10 illegal result", {32'h0, result}, 64'h0);
    check("R10 flag raised", {63'h0, illegal_op}, 64'h1);
    op_code = 3'd0; src_b = 32'hDEADBEEF; amount = 8'd4;
    @(negedge clk);
    check("R10 flag dropped", {63'h0, illegal_op}, 64'h0);
    check("R12 idle hold after illegal", {32'h0, result}, 64'h0);

    issue(3'd1, 32'h89ABCDEF, 32'h12345678, 8'd8);
    check("R11 negative ext", result_ext, 64'hFFFFFFFF_EF123456);
    src_a = 32'h0; src_b = 32'h0; op_code = 3'd3;
    repeat (3) @(negedge clk);
    check("R12 hold while idle", {32'h0, result}, {32'h0, 32'hEF123456});

    // reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 result after reset", {32'h0, result}, 64'h0);
    rst_n = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule